// File: doc/BRIEF.md
# Chroma Burst Inserter and Quadrature Modulator

This block takes the two colour-difference components of a video stream, one sample pair every fourth clock, and turns them into a modulated chrominance signal at the full clock rate. Each component is scaled by its own gain. During the colour-burst interval the incoming samples are replaced by a burst vector. The burst amplitude moves in a straight line from a programmable start level to a programmable end level. The direction of the burst depends on the selected colour standard: a fixed axis, or an axis that alternates from line to line.

The scaled or burst samples pass through two cascaded 2x interpolators. Together they raise the rate four times. The second interpolator can be switched to sample-and-hold, which gives a wider colour bandwidth. A 32-bit phase accumulator drives a sine table. The quadrature modulator multiplies the two components by sine and cosine and saturates the sum to a signed 10-bit output.

Top module: `chroma_burst_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `chroma_out` becomes 0, the phase accumulator becomes 0, and every pipeline register clears.
- R2: Inputs are sampled only at a clock edge with `smp_valid` high. Outside the burst, U = floor(cb_in*cb_gain/64) and V = floor(cr_in*cr_gain/64). The samples are signed 8-bit and the gains are unsigned 8-bit. Each gain affects only its own component.
- R3: `smp_valid` is high for one clock in every four, and never on two consecutive clocks.
- R4: The burst sample with index k (k = 0 for the first sample of a window with `burst_win` high, held at 15 from then on) has amplitude A = amp_start + floor((amp_end - amp_start)*k/16).
- R5: With `std_sel` = 0, a burst sample is U = -A and V = 0. The cb/cr inputs and the gains are ignored.
- R6: With `std_sel` = 1, a burst sample is U = -c with c = floor(A*181/256). V = +c in the 1st, 3rd, 5th... burst window since reset, and V = -c in the even-numbered windows.
- R7: Both interpolators are linear. Each input sample x with predecessor p produces floor((p+x)/2) followed by x, so a step from 0 to 64 appears as 16, 32, 48, 64 on successive clocks.
- R8: With `bypass` = 1, the second interpolator repeats each of its input samples on two successive clocks instead of inserting midpoints.
- R9: A 32-bit accumulator advances by `fsc_inc` every clock. The table index is bits 31..24. sin = T[idx] and cos = T[(idx+64) mod 256]. For i in 0..127 the table holds T[i] = floor(2032*q/(81920-4*q)) with q = i*(128-i), and T[i+128] = -T[i].
- R10: `chroma_out` = floor((U*sin + V*cos)/128), saturated to the range -512..511 and registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Strobe marking a new baseband sample pair |
| cb_in | input | 8 | Signed blue-difference sample |
| cr_in | input | 8 | Signed red-difference sample |
| cb_gain | input | 8 | Unsigned gain for cb, 64 = unity |
| cr_gain | input | 8 | Unsigned gain for cr, 64 = unity |
| burst_win | input | 1 | High while the sampled pair lies in the burst interval |
| std_sel | input | 1 | 0 = fixed burst axis, 1 = line-alternating burst axis |
| amp_start | input | 8 | Burst amplitude at the first burst sample |
| amp_end | input | 8 | Burst amplitude the ramp heads toward |
| fsc_inc | input | 32 | Subcarrier phase increment per clock |
| bypass | input | 1 | Turns the second interpolator into sample-and-hold |
| chroma_out | output | 10 | Signed modulated chrominance |

## Verification
From the ports, the hardest things to observe are a single component and the sign of the alternating burst, because the subcarrier phase normally rotates freely. The stimulus sets a known phase. It resets the block, then applies a quarter-cycle increment for exactly one clock and sets the increment to zero. This parks the table index on the pure-sine or the pure-cosine point, so the output reads U or V directly. Two burst windows after one reset expose the line alternation. An eighth-cycle increment with full-scale inputs passes through the 45-degree points, where both products add up beyond the output range.

// File: rtl/cbm_pkg.sv
// Shared types and constant functions for the chroma burst modulator.
// Assumes: the table depth is even and the amplitude fits the table width.
package cbm_pkg;

    // Burst axis selection
    typedef enum logic {
        STD_FIXED = 1'b0,
        STD_ALT   = 1'b1
    } std_e;

    // One sine table entry from a rational approximation over a half period
    function automatic int sine_entry(int idx, int depth, int amp);
        int half;
        int i;
        int q;
        int v;
        half = depth / 2;
        i    = idx % half;
        q    = i * (half - i);
        v    = (16 * amp * q) / (5 * half * half - 4 * q);
        return (idx >= half) ? -v : v;
    endfunction

endpackage

// File: rtl/cbm_gain_burst.sv
// Gain and burst stage: scales each colour-difference sample by its own gain,
// or replaces the pair with a ramped burst vector during the burst window.
// Assumes: smp_valid pulses for one clock per baseband sample, and the burst
// window spans 2**BURST_LOG2 samples or more for a full ramp.
module cbm_gain_burst #(
    parameter int IN_W       = 8,
    parameter int GAIN_W     = 8,
    parameter int GAIN_SHIFT = 6,
    parameter int AMP_W      = 8,
    parameter int BURST_LOG2 = 4,
    parameter int BB_W       = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic signed [IN_W-1:0] cb_in,
    input  logic signed [IN_W-1:0] cr_in,
    input  logic [GAIN_W-1:0]      cb_gain,
    input  logic [GAIN_W-1:0]      cr_gain,
    input  logic                   burst_win,
    input  logic                   std_sel,
    input  logic [AMP_W-1:0]       amp_start,
    input  logic [AMP_W-1:0]       amp_end,
    output logic signed [BB_W-1:0] u_q,
    output logic signed [BB_W-1:0] v_q,
    output logic                   vld_q
);
    import cbm_pkg::*;

    localparam int PW     = IN_W + GAIN_W + 1;
    localparam int AW     = AMP_W + 2;
    localparam int SW     = AW + BURST_LOG2 + 1;
    localparam int PAL_K  = 181;
    localparam int PALW   = AMP_W + 8;
    localparam logic [BURST_LOG2-1:0] K_MAX = '1;

    logic                    in_burst_q;
    logic [BURST_LOG2-1:0]   k_q;
    logic                    line_alt_q;
    logic [BURST_LOG2-1:0]   k_cur;
    logic signed [PW-1:0]    cb_prod, cr_prod, cb_sh, cr_sh;
    logic signed [BB_W-1:0]  gu, gv;
    logic signed [AW-1:0]    amp_diff;
    logic signed [SW-1:0]    ramp_prod, ramp_sh;
    logic [AW-1:0]           amp_sum;
    logic [AMP_W-1:0]        amp_now;
    logic [PALW-1:0]         pal_prod;
    logic signed [BB_W-1:0]  amp_ext, c_ext;
    logic signed [BB_W-1:0]  bu, bv;
    std_e                    std_mode;

    // Scale each component by its own gain
    always_comb begin
        cb_prod = $signed(cb_in) * $signed({1'b0, cb_gain});
        cr_prod = $signed(cr_in) * $signed({1'b0, cr_gain});
        cb_sh   = cb_prod >>> GAIN_SHIFT;
        cr_sh   = cr_prod >>> GAIN_SHIFT;
        gu      = cb_sh[BB_W-1:0];
        gv      = cr_sh[BB_W-1:0];
    end

    // Linear burst amplitude ramp from start to end over the window
    always_comb begin
        k_cur     = in_burst_q ? k_q : '0;
        amp_diff  = $signed({2'b00, amp_end}) - $signed({2'b00, amp_start});
        ramp_prod = amp_diff * $signed({1'b0, k_cur});
        ramp_sh   = ramp_prod >>> BURST_LOG2;
        amp_sum   = {2'b00, amp_start} + ramp_sh[AW-1:0];
        amp_now   = amp_sum[AMP_W-1:0];
        pal_prod  = amp_now * PALW'(PAL_K);
        amp_ext   = $signed({{(BB_W-AMP_W){1'b0}}, amp_now});
        c_ext     = $signed({{(BB_W-AMP_W){1'b0}}, pal_prod[PALW-1:8]});
    end

    // Burst vector direction for the selected standard
    always_comb begin
        std_mode = std_e'(std_sel);
        if (std_mode == STD_ALT) begin
            bu = -c_ext;
            bv = line_alt_q ? -c_ext : c_ext;
        end else begin
            bu = -amp_ext;
            bv = '0;
        end
    end

    // Register the selected sample pair and track window/line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q        <= '0;
            v_q        <= '0;
            vld_q      <= 1'b0;
            in_burst_q <= 1'b0;
            k_q        <= '0;
            line_alt_q <= 1'b0;
        end else begin
            vld_q <= smp_valid;
            if (smp_valid) begin
                u_q        <= burst_win ? bu : gu;
                v_q        <= burst_win ? bv : gv;
                in_burst_q <= burst_win;
                if (burst_win) begin
                    k_q <= (k_cur == K_MAX) ? k_cur : k_cur + 1'b1;
                end
                if (!burst_win && in_burst_q) begin
                    line_alt_q <= ~line_alt_q;
                end
            end
        end
    end

endmodule

// File: rtl/cbm_interp2x.sv
// Two-times interpolator: for every input it emits the midpoint with the
// previous input, then HALF clocks later the input itself. With hold set it
// emits the input twice (sample-and-hold).
// Assumes: inputs arrive at least 2*HALF clocks apart.
module cbm_interp2x #(
    parameter int W    = 10,
    parameter int HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    input  logic                hold,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    localparam int CW = $clog2(HALF + 1);

    logic signed [W-1:0] last_q;
    logic [CW-1:0]       cnt_q;
    logic signed [W:0]   pair_sum;
    logic signed [W-1:0] mid;

    // Floor midpoint of the new and the previous sample
    always_comb begin
        pair_sum = {in_data[W-1], in_data} + {last_q[W-1], last_q};
        mid      = pair_sum[W:1];
    end

    // Emit midpoint (or held value) now, then the sample itself later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= '0;
            cnt_q     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                out_data  <= hold ? in_data : mid;
                last_q    <= in_data;
                cnt_q     <= CW'(HALF);
                out_valid <= 1'b1;
            end else if (cnt_q == CW'(1)) begin
                out_data  <= last_q;
                cnt_q     <= '0;
                out_valid <= 1'b1;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cbm_quad_mod.sv
// Quadrature modulator: phase accumulator, computed sine table shared for
// both terms, product sum, scaling and saturation to the output width.
// Assumes: the table width is 8 and the component width matches BB_W.
module cbm_quad_mod #(
    parameter int BB_W    = 10,
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 8,
    parameter int LUT_W   = 8,
    parameter int OUT_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASE_W-1:0]       fsc_inc,
    input  logic                     data_vld,
    input  logic signed [BB_W-1:0]   u_in,
    input  logic signed [BB_W-1:0]   v_in,
    output logic signed [OUT_W-1:0]  mod_out
);
    localparam int LUT_DEPTH = 2 ** LUT_AW;
    localparam int LUT_AMP   = 2 ** (LUT_W - 1) - 1;
    localparam int MOD_SHIFT = LUT_W - 1;
    localparam int PROD_W    = BB_W + LUT_W;
    localparam int SUM_W     = PROD_W + 1;
    localparam logic [LUT_AW-1:0] COS_OFS = LUT_AW'(LUT_DEPTH / 4);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

    logic [PHASE_W-1:0]       acc_q;
    logic [LUT_AW-1:0]        idx_s, idx_c;
    logic signed [LUT_W-1:0]  lut [LUT_DEPTH];
    logic signed [LUT_W-1:0]  sin_v, cos_v;
    logic signed [PROD_W-1:0] prod_u, prod_v;
    logic signed [SUM_W-1:0]  sum, scaled;
    logic signed [OUT_W-1:0]  sat_v;

    // Sine table filled from a constant function
    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        assign lut[g] = LUT_W'(cbm_pkg::sine_entry(g, LUT_DEPTH, LUT_AMP));
    end

    // Table lookup, products, scaling and saturation
    always_comb begin
        idx_s  = acc_q[PHASE_W-1 -: LUT_AW];
        idx_c  = idx_s + COS_OFS;
        sin_v  = lut[idx_s];
        cos_v  = lut[idx_c];
        prod_u = u_in * sin_v;
        prod_v = v_in * cos_v;
        sum    = {prod_u[PROD_W-1], prod_u} + {prod_v[PROD_W-1], prod_v};
        scaled = sum >>> MOD_SHIFT;
        if (scaled > SAT_HI) begin
            sat_v = SAT_HI[OUT_W-1:0];
        end else if (scaled < SAT_LO) begin
            sat_v = SAT_LO[OUT_W-1:0];
        end else begin
            sat_v = scaled[OUT_W-1:0];
        end
    end

    // Advance subcarrier phase and register the modulated sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mod_out <= '0;
        end else begin
            acc_q <= acc_q + fsc_inc;
            if (data_vld) begin
                mod_out <= sat_v;
            end
        end
    end

endmodule

// File: rtl/chroma_burst_mod.sv
// Top of the chroma path: gain/burst stage, two cascaded 2x interpolators
// per component (second one optionally sample-and-hold), quadrature modulator.
// Assumes: smp_valid arrives exactly every fourth clock.
module chroma_burst_mod #(
    parameter int IN_W       = 8,
    parameter int GAIN_W     = 8,
    parameter int GAIN_SHIFT = 6,
    parameter int AMP_W      = 8,
    parameter int BURST_LOG2 = 4,
    parameter int BB_W       = 10,
    parameter int PHASE_W    = 32,
    parameter int LUT_AW     = 8,
    parameter int LUT_W      = 8,
    parameter int OUT_W      = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [IN_W-1:0]   cb_in,
    input  logic signed [IN_W-1:0]   cr_in,
    input  logic [GAIN_W-1:0]        cb_gain,
    input  logic [GAIN_W-1:0]        cr_gain,
    input  logic                     burst_win,
    input  logic                     std_sel,
    input  logic [AMP_W-1:0]         amp_start,
    input  logic [AMP_W-1:0]         amp_end,
    input  logic [PHASE_W-1:0]       fsc_inc,
    input  logic                     bypass,
    output logic signed [OUT_W-1:0]  chroma_out
);
    localparam int NCH = 2;

    logic signed [BB_W-1:0] u_gb, v_gb;
    logic                   gb_vld;
    logic signed [BB_W-1:0] ch_gb [NCH];
    logic signed [BB_W-1:0] s1_data [NCH];
    logic signed [BB_W-1:0] s2_data [NCH];
    logic [NCH-1:0]         s1_vld, s2_vld;
    logic signed [BB_W-1:0] u_s1, u_s2, v_s2;
    logic                   s1_vld_u;

    cbm_gain_burst #(
        .IN_W(IN_W), .GAIN_W(GAIN_W), .GAIN_SHIFT(GAIN_SHIFT),
        .AMP_W(AMP_W), .BURST_LOG2(BURST_LOG2), .BB_W(BB_W)
    ) u_gain_burst (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .cb_in(cb_in), .cr_in(cr_in), .cb_gain(cb_gain), .cr_gain(cr_gain),
        .burst_win(burst_win), .std_sel(std_sel),
        .amp_start(amp_start), .amp_end(amp_end),
        .u_q(u_gb), .v_q(v_gb), .vld_q(gb_vld)
    );

    assign ch_gb[0] = u_gb;
    assign ch_gb[1] = v_gb;

    // One interpolator chain per colour component
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cbm_interp2x #(.W(BB_W), .HALF(2)) u_stage1 (
            .clk(clk), .rst_n(rst_n), .in_valid(gb_vld), .in_data(ch_gb[c]),
            .hold(1'b0), .out_valid(s1_vld[c]), .out_data(s1_data[c])
        );
        cbm_interp2x #(.W(BB_W), .HALF(1)) u_stage2 (
            .clk(clk), .rst_n(rst_n), .in_valid(s1_vld[c]), .in_data(s1_data[c]),
            .hold(bypass), .out_valid(s2_vld[c]), .out_data(s2_data[c])
        );
    end

    assign u_s1     = s1_data[0];
    assign u_s2     = s2_data[0];
    assign v_s2     = s2_data[1];
    assign s1_vld_u = s1_vld[0];

    cbm_quad_mod #(
        .BB_W(BB_W), .PHASE_W(PHASE_W), .LUT_AW(LUT_AW),
        .LUT_W(LUT_W), .OUT_W(OUT_W)
    ) u_quad_mod (
        .clk(clk), .rst_n(rst_n), .fsc_inc(fsc_inc),
        .data_vld(&s2_vld), .u_in(u_s2), .v_in(v_s2), .mod_out(chroma_out)
    );

endmodule

// File: rtl/cbm_checker.sv
// Property checker for chroma_burst_mod, attached by bind.
// Assumes: reset is synchronous and active low.
module cbm_checker #(
    parameter int BB_W  = 10,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic                    burst_win,
    input logic                    std_sel,
    input logic                    bypass,
    input logic signed [BB_W-1:0]  u0,
    input logic signed [BB_W-1:0]  v0,
    input logic                    s1_vld,
    input logic signed [BB_W-1:0]  u1,
    input logic signed [BB_W-1:0]  u2,
    input logic signed [BB_W-1:0]  v2,
    input logic signed [OUT_W-1:0] chroma_out
);
    // R3: strobe never on two consecutive clocks
    assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R5: fixed-axis burst carries no V component
    assert_fixed_burst_v_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && burst_win && !std_sel) |=> (v0 == '0));

    // R6: alternating burst lies on a diagonal with non-positive U
    assert_alt_burst_diag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && burst_win && std_sel) |=> ((u0 <= 0) && ((v0 == u0) || (v0 == -u0))));

    // R7: first interpolator never emits on consecutive clocks
    assert_stage1_cadence_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> !s1_vld);

    // R8: in bypass the second stage passes its input unchanged
    assert_bypass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && bypass) |=> (u2 == $past(u1)));

    // R10: zero components give zero output
    assert_zero_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((u2 == '0) && (v2 == '0)) |=> (chroma_out == '0));

endmodule

bind chroma_burst_mod cbm_checker #(.BB_W(BB_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .burst_win(burst_win),
    .std_sel(std_sel), .bypass(bypass), .u0(u_gb), .v0(v_gb),
    .s1_vld(s1_vld_u), .u1(u_s1), .u2(u_s2), .v2(v_s2), .chroma_out(chroma_out)
);

// File: tb/tb_chroma_burst_mod.sv
module tb_chroma_burst_mod;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] cb_in = '0, cr_in = '0;
    logic [7:0]        cb_gain = 8'd64, cr_gain = 8'd64;
    logic              burst_win = 1'b0, std_sel = 1'b0, bypass = 1'b0;
    logic [7:0]        amp_start = '0, amp_end = '0;
    logic [31:0]       fsc_inc = '0;
    logic signed [9:0] chroma_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    chroma_burst_mod dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cb_in(cb_in), .cr_in(cr_in),
        .cb_gain(cb_gain), .cr_gain(cr_gain), .burst_win(burst_win), .std_sel(std_sel),
        .amp_start(amp_start), .amp_end(amp_end), .fsc_inc(fsc_inc), .bypass(bypass),
        .chroma_out(chroma_out)
    );

    always #4 clk = ~clk;

    // Sample strobe: one clock high in every four (R3)
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
        end
    end

    // Table entry from the R9 formula
    function automatic int tbl(int idx);
        int i = idx % 128;
        int q = i * (128 - i);
        int v = (2032 * q) / (81920 - 4 * q);
        return (idx % 256 >= 128) ? -v : v;
    endfunction

    // Expected output per R10 at a given table index
    function automatic int model(int u, int v, int idx);
        int s = (u * tbl(idx) + v * tbl(idx + 64)) >>> 7;
        if (s > 511) s = 511;
        if (s < -512) s = -512;
        return s;
    endfunction

    function automatic int gain(int x, int g);
        return (x * g) >>> 6;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reset; optionally park the table index at 64 (pure sine)
    task automatic do_reset(bit park64);
        @(negedge clk);
        rst_n = 1'b0; burst_win = 1'b0; fsc_inc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        if (park64) begin
            fsc_inc = 32'h4000_0000;
            @(negedge clk);
            fsc_inc = '0;
        end
    endtask

    task automatic settle();
        repeat (48) @(negedge clk);
    endtask

    task automatic wait_strobe();
        do @(posedge clk); while (!smp_valid);
    endtask

    // Run one 16-sample burst window; return mid-window value and minimum
    task automatic run_window(output int mid_v, output int min_v);
        int strb = 0;
        bit got = 1'b0;
        wait_strobe();
        @(negedge clk);
        burst_win = 1'b1;
        min_v = 1000; mid_v = 0;
        while (strb < 16) begin
            @(posedge clk);
            if (smp_valid) strb++;
            @(negedge clk);
            if (strb == 16) burst_win = 1'b0;
            if (int'(chroma_out) < min_v) min_v = int'(chroma_out);
            if (strb == 10 && !got) begin mid_v = int'(chroma_out); got = 1'b1; end
        end
        repeat (40) begin
            @(negedge clk);
            if (int'(chroma_out) < min_v) min_v = int'(chroma_out);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; cr_in = 8'sd100; cb_in = 8'sd100;
        repeat (3) @(negedge clk);
        chk("R1 reset output", int'(chroma_out), 0);
        rst_n = 1'b1; cr_in = '0; cb_in = '0;
        settle();
        chk("R1 idle output", int'(chroma_out), 0);
    endtask

    task automatic t_gain();
        do_reset(1'b0);
        cb_in = 8'sd90; cb_gain = 8'd200; cr_in = 8'sd100; cr_gain = 8'd96;
        settle();
        chk("R2 cr gain", int'(chroma_out), model(0, gain(100, 96), 0));
        cr_in = -8'sd100; cr_gain = 8'd32;
        settle();
        chk("R2 cr negative", int'(chroma_out), model(0, gain(-100, 32), 0));
        do_reset(1'b1);
        cb_in = -8'sd50; cb_gain = 8'd200; cr_in = 8'sd77; cr_gain = 8'd255;
        settle();
        chk("R2 cb gain independent", int'(chroma_out), model(gain(-50, 200), 0, 64));
    endtask

    task automatic t_quad();
        int a [4];
        int e [4];
        int r = 0;
        do_reset(1'b0);
        cb_in = -8'sd30; cb_gain = 8'd64; cr_in = 8'sd70; cr_gain = 8'd64;
        fsc_inc = 32'h4000_0000;
        settle();
        for (int i = 0; i < 4; i++) begin
            a[i] = int'(chroma_out);
            e[i] = model(-30, 70, 64 * i);
            @(negedge clk);
        end
        for (int j = 0; j < 4; j++) if (a[0] == e[j]) r = j;
        for (int i = 0; i < 4; i++) chk("R9 quadrature sequence", a[i], e[(r + i) % 4]);
        fsc_inc = '0;
    endtask

    task automatic t_interp(bit hold, int e0, int e1, int e2, int e3);
        int a [4];
        int n = 0;
        string tag;
        tag = hold ? "R8 bypass hold" : "R7 linear interp";
        do_reset(1'b0);
        bypass = hold; cr_in = '0; cb_in = '0; cr_gain = 8'd64;
        settle();
        cr_in = 8'sd64;
        while (chroma_out == '0 && n < 40) begin @(negedge clk); n++; end
        for (int i = 0; i < 4; i++) begin
            a[i] = int'(chroma_out);
            @(negedge clk);
        end
        chk(tag, a[0], e0); chk(tag, a[1], e1); chk(tag, a[2], e2); chk(tag, a[3], e3);
        bypass = 1'b0;
    endtask

    task automatic t_burst_fixed();
        int mid_v, min_v;
        do_reset(1'b1);
        std_sel = 1'b0; amp_start = 8'd100; amp_end = 8'd100;
        cb_in = 8'sd60; cb_gain = 8'd64;
        settle();
        run_window(mid_v, min_v);
        chk("R5 fixed burst U", mid_v, model(-100, 0, 64));
        do_reset(1'b0);
        cr_in = 8'sd40; cr_gain = 8'd64;
        settle();
        chk("R2 cr before burst", int'(chroma_out), model(0, 40, 0));
        run_window(mid_v, min_v);
        chk("R5 fixed burst V ignored input", mid_v, 0);
        cr_in = '0; cb_in = '0;
    endtask

    task automatic t_burst_alt();
        int mid_v, min_v;
        int c = (100 * 181) >>> 8;
        do_reset(1'b0);
        std_sel = 1'b1; amp_start = 8'd100; amp_end = 8'd100;
        cb_in = '0; cr_in = '0;
        settle();
        run_window(mid_v, min_v);
        chk("R6 alt burst first window", mid_v, model(-c, c, 0));
        run_window(mid_v, min_v);
        chk("R6 alt burst second window", mid_v, model(-c, -c, 0));
        run_window(mid_v, min_v);
        chk("R6 alt burst third window", mid_v, model(-c, c, 0));
        std_sel = 1'b0;
    endtask

    task automatic t_ramp();
        int mid_v, min_v;
        do_reset(1'b1);
        std_sel = 1'b0; cb_in = '0; cr_in = '0;
        amp_start = 8'd0; amp_end = 8'd128;
        settle();
        run_window(mid_v, min_v);
        chk("R4 rising ramp peak", min_v, model(-(0 + ((128 * 15) >>> 4)), 0, 64));
        chk("R4 rising ramp mid", mid_v < 0 && mid_v > min_v ? 1 : 0, 1);
        amp_start = 8'd128; amp_end = 8'd0;
        run_window(mid_v, min_v);
        chk("R4 falling ramp peak", min_v, model(-128, 0, 64));
    endtask

    task automatic t_sat();
        int mx = -1000, mn = 1000;
        do_reset(1'b0);
        cb_in = 8'sd127; cr_in = 8'sd127; cb_gain = 8'd255; cr_gain = 8'd255;
        fsc_inc = 32'h2000_0000;
        settle();
        for (int i = 0; i < 16; i++) begin
            if (int'(chroma_out) > mx) mx = int'(chroma_out);
            if (int'(chroma_out) < mn) mn = int'(chroma_out);
            @(negedge clk);
        end
        chk("R10 saturate high", mx, 511);
        chk("R10 saturate low", mn, -512);
        fsc_inc = '0; cb_in = '0; cr_in = '0; cb_gain = 8'd64; cr_gain = 8'd64;
    endtask

    initial begin
        t_reset();
        t_gain();
        t_quad();
        t_interp(1'b0, model(0, 16, 0), model(0, 32, 0), model(0, 48, 0), model(0, 64, 0));
        t_interp(1'b1, model(0, 32, 0), model(0, 32, 0), model(0, 64, 0), model(0, 64, 0));
        t_burst_fixed();
        t_burst_alt();
        t_ramp();
        t_sat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule